// File: doc/BRIEF.md
# Strobe-Synchronised Adaptive Clock Divider

This block derives a slow clock for a peripheral from a fast processor clock. No register sets the division ratio. The block watches the processor's address-latch strobe. Each rising edge of that strobe restarts the output phase, so the slow clock stays lined up with bus cycles. The block also measures the spacing between consecutive strobe edges. Strobes that come six fast clocks apart give a divide-by-six output, which is the normal rate. When every second strobe is dropped, the edges come twelve clocks apart and the output switches to divide-by-four.

The output and the ratio flag both come straight from flip-flops. A thin top joins two modules. The control module detects strobe edges, counts the spacing between them and decides the ratio. The datapath module holds the phase counter, the clock register and the ratio register. The two talk through a small struct of strobes.

Top module: `strobeClockDivider`

## Requirements
- R1: While `rst` is high at a clock edge, `divClk` and `ratioFour` are both 0 after that edge.
- R2: When strobe rising edges arrive every 6 clocks, `divClk` is 1 for three clocks and 0 for three clocks. It rises in the cycle right after the edge that sampled the strobe rising, and `ratioFour` reads 0.
- R3: When rising edges arrive exactly 12 clocks apart, the strobe edge that closes a 12-clock spacing sets `ratioFour` to 1. From then on `divClk` runs 1 for two clocks and 0 for two clocks, giving three output periods per strobe interval.
- R4: With strobes at the nominal 6-clock spacing, or at the 12-clock spacing, every high phase and every low phase of `divClk` lasts at least two clock periods.
- R5: The ratio comes only from the strobe spacing, and `ratioFour` changes only at the start of an output period. A period starts at a strobe edge or at a counter wrap.
- R6: With no strobe edges, the output free-runs at divide-by-six. Once 12 clocks pass with no strobe edge, the next period start clears `ratioFour` to 0. This includes the first cycles after reset.
- R7: A strobe edge that comes 6 clocks after the previous one, while in divide-by-four, returns the block to divide-by-six with `ratioFour` 0.
- R8: A strobe edge at any spacing other than 12 restarts the phase with `divClk` high and selects divide-by-six, even in the middle of a period.
- R9: Only a 0-to-1 transition of `busStrobe` counts. Holding the strobe high for several clocks neither restarts the phase again nor changes the ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast processor clock |
| rst | input | 1 | Synchronous active-high reset |
| busStrobe | input | 1 | Address-latch strobe, synchronous to `clk` |
| divClk | output | 1 | Divided peripheral clock, driven from a register |
| ratioFour | output | 1 | 1 while dividing by four, 0 while dividing by six |

## Verification
The bench drives a 6-clock strobe stream, then a single 12-clock spacing. A design that measured the spacing wrongly would switch to divide-by-four too early, or never. A design that updated the flag at the wrong time would show it toggling in the middle of a period.

It also stops the strobes while in divide-by-four. A block with no timeout would keep the 2/2 pattern forever.

Early strobes mid-period, in both modes, expose a counter that fails to realign or that keeps the fast ratio. A strobe held high for several cycles catches a level-sensitive detector, which would pin the output high and fall back to divide-by-six.

// File: rtl/strobeDivPkg.sv
package strobeDivPkg;

  // Control-to-datapath strobes for one clock cycle
  typedef struct packed {
    logic periodStart;  // begin a new output period (phase 0, output high)
    logic ratioLoad;    // write the ratio register at this period start
    logic ratioFour;    // value to write: 1 = divide by four
  } divCtrlT;

endpackage

// File: rtl/strobeDivCtrl.sv
module strobeDivCtrl
  import strobeDivPkg::*;
#(
  parameter int SLOW_HALF = 3,
  parameter int GAP_W     = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    busStrobe,
  input  logic    phaseLast,
  output divCtrlT ctrl
);

  localparam int SLOW_PER = 2 * SLOW_HALF;
  localparam int LONG_GAP = 2 * SLOW_PER;   // one strobe dropped
  localparam int GAP_MAX  = LONG_GAP + 1;   // saturation: strobe overdue

  logic             strobeQ;
  logic [GAP_W-1:0] gapCnt;   // clocks since the last rising edge, 1-based
  logic             strobeRise;
  logic             gapLong;
  logic             gapOverdue;

  assign strobeRise = busStrobe & ~strobeQ;
  assign gapLong    = (gapCnt == GAP_W'(LONG_GAP));
  assign gapOverdue = (gapCnt >= GAP_W'(LONG_GAP));

  always_ff @(posedge clk) begin
    if (rst) begin
      strobeQ <= 1'b0;
      gapCnt  <= GAP_W'(GAP_MAX);
    end else begin
      strobeQ <= busStrobe;
      if (strobeRise)
        gapCnt <= GAP_W'(1);
      else if (gapCnt != GAP_W'(GAP_MAX))
        gapCnt <= gapCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.periodStart = strobeRise | phaseLast;
    ctrl.ratioLoad   = strobeRise | (phaseLast & gapOverdue);
    ctrl.ratioFour   = strobeRise & gapLong;
  end

  // R6: the spacing counter never wraps back to zero, so an overdue strobe stays visible
  gap_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    gapCnt != '0);

  // R8: a rising edge always restarts the spacing count at one
  gap_restart_chk: assert property (@(posedge clk) disable iff (rst)
    strobeRise |=> gapCnt == GAP_W'(1));

endmodule

// File: rtl/strobeDivPath.sv
module strobeDivPath
  import strobeDivPkg::*;
#(
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  divCtrlT ctrl,
  output logic    phaseLast,
  output logic    divClk,
  output logic    ratioFour
);

  localparam int PH_W      = $clog2(2 * SLOW_HALF);
  localparam int SLOW_LAST = 2 * SLOW_HALF - 1;
  localparam int FAST_LAST = 2 * FAST_HALF - 1;

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] halfLen;
  logic [PH_W-1:0] lastPhase;
  logic [PH_W-1:0] phaseNext;

  assign halfLen   = ratioFour ? PH_W'(FAST_HALF) : PH_W'(SLOW_HALF);
  assign lastPhase = ratioFour ? PH_W'(FAST_LAST) : PH_W'(SLOW_LAST);
  assign phaseLast = (phase == lastPhase);
  assign phaseNext = phase + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_W'(SLOW_LAST);
      divClk    <= 1'b0;
      ratioFour <= 1'b0;
    end else if (ctrl.periodStart) begin
      phase  <= '0;
      divClk <= 1'b1;
      if (ctrl.ratioLoad)
        ratioFour <= ctrl.ratioFour;
    end else begin
      phase  <= phaseNext;
      divClk <= (phaseNext < halfLen);
    end
  end

  // R4: a high phase never lasts a single cycle
  high_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(divClk) |=> divClk);

  // R5: the ratio flag changes only where a new period begins
  ratio_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratioFour) |-> (phase == '0 && divClk));

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    ratioFour |-> phase <= PH_W'(FAST_LAST));

  // R8: every period start lands on phase zero with the output high
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.periodStart |=> (phase == '0 && divClk));

endmodule

// File: rtl/strobeClockDivider.sv
module strobeClockDivider
  import strobeDivPkg::*;
#(
  parameter int SLOW_HALF = 3,
  parameter int FAST_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic busStrobe,
  output logic divClk,
  output logic ratioFour
);

  localparam int GAP_W = $clog2(4 * SLOW_HALF + 2);

  divCtrlT ctrl;
  logic    phaseLast;

  strobeDivCtrl #(
    .SLOW_HALF(SLOW_HALF),
    .GAP_W    (GAP_W)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .busStrobe(busStrobe),
    .phaseLast(phaseLast),
    .ctrl     (ctrl)
  );

  strobeDivPath #(
    .SLOW_HALF(SLOW_HALF),
    .FAST_HALF(FAST_HALF)
  ) uPath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .phaseLast(phaseLast),
    .divClk   (divClk),
    .ratioFour(ratioFour)
  );

  // R1: reset holds the output low
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!divClk && !ratioFour));

endmodule

// File: tb/strobeClockDivider_test.sv
module strobeClockDivider_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busStrobe = 1'b0;
  logic divClk;
  logic ratioFour;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  strobeClockDivider uut (
    .clk      (clk),
    .rst      (rst),
    .busStrobe(busStrobe),
    .divClk   (divClk),
    .ratioFour(ratioFour)
  );

  task automatic checkBit(input logic actual, input logic expected,
                          input string req, input string what);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, actual, expected, $time);
    end
  endtask

  // n cycles; strobe high for the first `pulse` cycles; expect `hi` high of each `per`
  task automatic runSeg(input int n, input int pulse, input int hi, input int per,
                        input logic flag, input string req);
    for (int i = 0; i < n; i++) begin
      busStrobe = (i < pulse);
      @(posedge clk); #1;
      checkBit(divClk, logic'((i % per) < hi), req, "divClk");
      checkBit(ratioFour, flag, req, "ratioFour");
    end
    busStrobe = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1;
    checkBit(divClk, 1'b0, "R1", "divClk in reset");
    checkBit(ratioFour, 1'b0, "R1", "ratioFour in reset");
    rst = 1'b0;
  endtask

  task automatic testFreeRunAfterReset();
    runSeg(12, 0, 3, 6, 1'b0, "R6");
  endtask

  task automatic testSixSpacing();
    repeat (3) runSeg(6, 1, 3, 6, 1'b0, "R2 R4");
  endtask

  task automatic testFourSpacing();
    runSeg(6, 1, 3, 6, 1'b0, "R5");
    runSeg(6, 0, 3, 6, 1'b0, "R5");          // flag holds until the strobe closes 12
    repeat (3) runSeg(12, 1, 2, 4, 1'b1, "R3 R4 R5");
  endtask

  task automatic testHeldStrobe();
    runSeg(12, 5, 2, 4, 1'b1, "R9");
  endtask

  task automatic testTimeout();
    runSeg(12, 1, 2, 4, 1'b1, "R3");
    runSeg(12, 0, 3, 6, 1'b0, "R6");
    runSeg(6, 0, 3, 6, 1'b0, "R6");
  endtask

  task automatic testBackToSix();
    runSeg(12, 1, 3, 6, 1'b0, "R6");          // overdue strobe keeps divide-by-six
    runSeg(12, 1, 2, 4, 1'b1, "R3");
    runSeg(6, 1, 2, 4, 1'b1, "R3");
    runSeg(6, 1, 3, 6, 1'b0, "R7");
  endtask

  task automatic testEarlyStrobe();
    runSeg(4, 1, 3, 6, 1'b0, "R8");           // 1,1,1,0 then realigned
    runSeg(6, 1, 3, 6, 1'b0, "R8");
    runSeg(6, 0, 3, 6, 1'b0, "R8");
    runSeg(5, 1, 2, 4, 1'b1, "R8");           // 12 spacing: four, cut after 5
    runSeg(6, 1, 3, 6, 1'b0, "R8");           // spacing 5 from four: six again
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testFreeRunAfterReset();
    testSixSpacing();
    testFourSpacing();
    testHeldStrobe();
    testTimeout();
    testBackToSix();
    testEarlyStrobe();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule